// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Unit

This block is a sequential execution unit that shifts or rotates an 8-, 16- or 32-bit operand by a variable count. It supports arithmetic and logical shifts in both directions, plain rotates in both directions, and rotates that run through an extend bit. A single cycle of `start_i` loads the operand, the operation, the size, the count and the incoming extend flag. The unit then stays busy for a number of cycles that depends on the count and the operand size. It raises `done_o` for one cycle, and from that cycle on it presents the result together with carry, extend, negative, zero and overflow flags.

The datapath moves the working value by one bit position per cycle. The result and flag outputs are registered, and they change only when an operation completes. A count of zero takes its own path: it passes the operand through and applies fixed flag rules. The unit is meant to sit behind an instruction decoder, which drives the operation code and waits for `done_o`.

Top module: `shrot_unit`

## Requirements
- R1: Only the low 6 bits of `count_i` are used, so the effective count runs from 0 to 63 and the upper bits of `count_i` have no effect on the result, the flags or the latency.
- R2: With an effective count of zero, the result equals the size-masked operand and overflow is 0. Extend keeps `extend_i`. Carry is 0, except for the two rotate-through-extend operations, where carry equals `extend_i`.
- R3: `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the size are ignored and the matching result bits are 0. Negative is the top bit of the selected size, and zero is set when the selected bits are all 0.
- R4: Shifts use `op_i` 0 = arithmetic left, 1 = arithmetic right, 2 = logical left, 3 = logical right. Left shifts fill with 0 from the bottom. Logical right fills with 0 from the top. Arithmetic right copies the top bit. Carry is the last bit shifted out, and for a non-zero count extend equals carry. Counts at or beyond the size are valid.
- R5: Plain rotates use `op_i` 4 = left and 5 = right. Bits leaving one end enter at the other end. For a non-zero count, carry is the last bit that crossed over. Extend always keeps `extend_i`.
- R6: Rotates through extend use `op_i` 6 = left and 7 = right. They rotate a ring of size+1 bits with the extend bit placed directly above the top operand bit, by (effective count modulo (size+1)) positions. Carry and extend both equal the final extend bit.
- R7: Overflow is set for arithmetic left shift if the top bit of the operand changes value at any step of the shift. For all other operations overflow is 0.
- R8: For a start accepted at clock edge E, `done_o` is high during the cycle that follows edge E+L. L is the effective count plus 2 for 32-bit operations, and the effective count plus 1 for 8- and 16-bit operations. The count used here is the masked count, taken before any modulo reduction.
- R9: `busy_o` is high from the accepting edge until the edge that raises `done_o`. `done_o` is high for exactly one cycle.
- R10: A start is accepted only while idle. A start during busy changes neither the running operation nor its latency. The result and flag outputs hold their values until the next operation completes.
- R11: After reset, `busy_o`, `done_o`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 3 | Operation code (see R4 to R6) |
| size_i | input | 2 | Operand size select (see R3) |
| operand_i | input | 32 | Operand |
| count_i | input | CNT_W | Shift count; only the low 6 bits are used |
| extend_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Result, zero-extended from the selected size |
| carry_o | output | 1 | Carry flag |
| extend_o | output | 1 | Extend flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The result and flags of a start accepted at edge E are first valid in the cycle after edge E+L. Here L is the masked count plus 1, or plus 2 at 32 bits, and `done_o` rises in that same cycle. The bench drives inputs on falling edges and counts rising edges from the accepting edge until it sees `done_o` on a falling edge. It checks that this count equals L, and it samples every output at that same falling edge. It then confirms that `done_o` has dropped one cycle later. In the second cycle of each busy period it also confirms that the previous result is still held, which covers the case where a start is injected while the unit is busy.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int DW    = 32;
  localparam int CW    = 6;
  localparam int NLANE = 3;

  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROXL = 3'd6,
    OP_ROXR = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_B  = 2'd0,
    SZ_H  = 2'd1,
    SZ_W  = 2'd2,
    SZ_W2 = 2'd3
  } size_e;

  function automatic int lane_idx(size_e s);
    case (s)
      SZ_B:    return 0;
      SZ_H:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [DW-1:0] size_mask(size_e s);
    case (s)
      SZ_B:    return 32'h0000_00ff;
      SZ_H:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic is_rox(op_e o);
    return (o == OP_ROXL) || (o == OP_ROXR);
  endfunction

  function automatic logic is_rot(op_e o);
    return (o == OP_ROL) || (o == OP_ROR);
  endfunction
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          long_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          finish_o
);
  localparam int LW = CW + 1;

  logic          busy_q, done_q;
  logic [LW-1:0] rem_q, lat;

  assign lat      = LW'(cnt_i) + (long_i ? LW'(2) : LW'(1));
  assign load_o   = start_i & ~busy_q;
  assign finish_o = busy_q & (rem_q == LW'(1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= finish_o;
      if (load_o) begin
        busy_q <= 1'b1;
        rem_q  <= lat;
      end else if (busy_q) begin
        if (finish_o) busy_q <= 1'b0;
        rem_q <= rem_q - LW'(1);
      end
    end
  end

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(busy_q));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !finish_o) |=> (busy_q && rem_q == $past(rem_q) - LW'(1)));
endmodule

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  logic          x_i,
  input  op_e           op_i,
  input  size_e         size_i,
  output logic [DW-1:0] val_o,
  output logic          x_o,
  output logic          c_o,
  output logic          vflip_o
);
  logic [DW-1:0] lane_val [NLANE];
  logic          lane_c   [NLANE];
  logic          lane_x   [NLANE];
  logic          lane_vf  [NLANE];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int W = 8 << k;
    logic [W-1:0] iv, ov;
    logic         msb, lsb, c;

    assign iv  = val_i[W-1:0];
    assign msb = iv[W-1];
    assign lsb = iv[0];

    always_comb begin
      ov = iv;
      c  = 1'b0;
      case (op_i)
        OP_ASL, OP_LSL: begin ov = {iv[W-2:0], 1'b0}; c = msb; end
        OP_ASR:         begin ov = {msb, iv[W-1:1]};  c = lsb; end
        OP_LSR:         begin ov = {1'b0, iv[W-1:1]}; c = lsb; end
        OP_ROL:         begin ov = {iv[W-2:0], msb};  c = msb; end
        OP_ROR:         begin ov = {lsb, iv[W-1:1]};  c = lsb; end
        OP_ROXL:        begin ov = {iv[W-2:0], x_i};  c = msb; end
        OP_ROXR:        begin ov = {x_i, iv[W-1:1]};  c = lsb; end
        default:        begin ov = iv;                c = 1'b0; end
      endcase
    end

    assign lane_val[k] = DW'(ov);
    assign lane_c[k]   = c;
    // plain rotates leave extend alone; all others carry it with the out-bit
    assign lane_x[k]   = is_rot(op_i) ? x_i : c;
    assign lane_vf[k]  = (op_i == OP_ASL) && (iv[W-1] != iv[W-2]);
  end

  always_comb begin
    val_o   = lane_val[lane_idx(size_i)];
    c_o     = lane_c[lane_idx(size_i)];
    x_o     = lane_x[lane_idx(size_i)];
    vflip_o = lane_vf[lane_idx(size_i)];
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  size_e         size_i,
  output logic          n_o,
  output logic          z_o
);
  logic [DW-1:0] mval;

  assign mval = val_i & size_mask(size_i);
  assign z_o  = (mval == '0);

  always_comb begin
    case (size_i)
      SZ_B:    n_o = val_i[7];
      SZ_H:    n_o = val_i[15];
      default: n_o = val_i[DW-1];
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      operand_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             extend_i,
  output logic [31:0]      result_o,
  output logic             carry_o,
  output logic             extend_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             done_o
);
  op_e           op_in;
  size_e         size_in;
  logic [CW-1:0] cnt6, rox_steps;
  logic          long_in, load, finish;

  assign op_in   = op_e'(op_i);
  assign size_in = size_e'(size_i);
  assign cnt6    = count_i[CW-1:0];
  assign long_in = (size_in != SZ_B) && (size_in != SZ_H);

  always_comb begin
    case (size_in)
      SZ_B:    rox_steps = cnt6 % CW'(9);
      SZ_H:    rox_steps = cnt6 % CW'(17);
      default: rox_steps = cnt6 % CW'(33);
    endcase
  end

  shrot_ctrl #(.CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cnt_i    (cnt6),
    .long_i   (long_in),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .load_o   (load),
    .finish_o (finish)
  );

  // working state
  op_e           op_q;
  size_e         size_q;
  logic [DW-1:0] val_q, opnd_q;
  logic [CW-1:0] steps_q;
  logic          x_q, c_q, v_q, xin_q, zcnt_q;

  logic [DW-1:0] st_val;
  logic          st_x, st_c, st_vf;

  shrot_step u_step (
    .val_i   (val_q),
    .x_i     (x_q),
    .op_i    (op_q),
    .size_i  (size_q),
    .val_o   (st_val),
    .x_o     (st_x),
    .c_o     (st_c),
    .vflip_o (st_vf)
  );

  logic fl_n, fl_z;

  shrot_flags u_flags (
    .val_i  (val_q),
    .size_i (size_q),
    .n_o    (fl_n),
    .z_o    (fl_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_ASL;
      size_q  <= SZ_B;
      val_q   <= '0;
      opnd_q  <= '0;
      steps_q <= '0;
      x_q     <= 1'b0;
      c_q     <= 1'b0;
      v_q     <= 1'b0;
      xin_q   <= 1'b0;
      zcnt_q  <= 1'b0;
    end else if (load) begin
      op_q    <= op_in;
      size_q  <= size_in;
      val_q   <= operand_i & size_mask(size_in);
      opnd_q  <= operand_i & size_mask(size_in);
      steps_q <= is_rox(op_in) ? rox_steps : cnt6;
      x_q     <= extend_i;
      c_q     <= is_rox(op_in) ? extend_i : 1'b0;
      v_q     <= 1'b0;
      xin_q   <= extend_i;
      zcnt_q  <= (cnt6 == '0);
    end else if (busy_o && steps_q != '0) begin
      val_q   <= st_val;
      x_q     <= st_x;
      c_q     <= st_c;
      v_q     <= v_q | st_vf;
      steps_q <= steps_q - CW'(1);
    end
  end

  // outputs registered at completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      extend_o <= 1'b0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
    end else if (finish) begin
      result_o <= val_q;
      carry_o  <= c_q;
      extend_o <= x_q;
      neg_o    <= fl_n;
      zero_o   <= fl_z;
      ovf_o    <= v_q;
    end
  end

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(result_o));

  a_r7_ovf_only_asl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q != OP_ASL) |-> !ovf_o);

  a_r2_zero_count_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zcnt_q) |-> (result_o == opnd_q && !ovf_o && extend_o == xin_q));

  a_r5_rot_keeps_extend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_rot(op_q)) |-> (extend_o == xin_q));

  a_r6_rox_carry_is_extend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_rox(op_q)) |-> (carry_o == extend_o));
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [2:0]       op_i = '0;
  logic [1:0]       size_i = '0;
  logic [31:0]      operand_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic             extend_i = 1'b0;
  logic [31:0]      result_o;
  logic             carry_o, extend_o, neg_o, zero_o, ovf_o, busy_o, done_o;

  shrot_unit #(.CNT_W(CNT_W)) u_shrot_unit (
    .clk_i, .rst_ni, .start_i, .op_i, .size_i, .operand_i, .count_i, .extend_i,
    .result_o, .carry_o, .extend_o, .neg_o, .zero_o, .ovf_o, .busy_o, .done_o
  );

  always #5 clk_i = ~clk_i;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] prev_res = '0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ref_model(input int op, input int sz, input logic [31:0] opnd, input int cnt_raw,
                           input logic xin, output logic [31:0] r, output logic c, output logic x,
                           output logic n, output logic z, output logic v, output int lat);
    int w, cnt, steps;
    logic [31:0] m, val;
    logic msb, lsb;
    w     = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m     = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
    cnt   = cnt_raw & 63;
    steps = (op >= 6) ? (cnt % (w + 1)) : cnt;
    val   = opnd & m;
    c     = (op >= 6) ? xin : 1'b0;
    x     = xin;
    v     = 1'b0;
    for (int i = 0; i < steps; i++) begin
      msb = val[w-1];
      lsb = val[0];
      case (op)
        0: begin val = (val << 1) & m; c = msb; x = msb; if (val[w-1] != msb) v = 1'b1; end
        1: begin val = (val >> 1) | ({31'd0, msb} << (w - 1)); c = lsb; x = lsb; end
        2: begin val = (val << 1) & m; c = msb; x = msb; end
        3: begin val = val >> 1; c = lsb; x = lsb; end
        4: begin val = ((val << 1) & m) | {31'd0, msb}; c = msb; end
        5: begin val = (val >> 1) | ({31'd0, lsb} << (w - 1)); c = lsb; end
        6: begin val = ((val << 1) & m) | {31'd0, x}; x = msb; c = msb; end
        default: begin val = (val >> 1) | ({31'd0, x} << (w - 1)); x = lsb; c = lsb; end
      endcase
    end
    r   = val;
    n   = val[w-1];
    z   = (val == 32'd0);
    lat = cnt + ((w == 32) ? 2 : 1);
  endtask

  task automatic run_op(input int op, input int sz, input logic [31:0] opnd, input int cnt_raw,
                        input logic xin, input bit inject);
    logic [31:0] er;
    logic ec, ex, en, ez, ev;
    int elat, k;
    string fam;
    ref_model(op, sz, opnd, cnt_raw, xin, er, ec, ex, en, ez, ev, elat);
    fam = ((cnt_raw & 63) == 0) ? "R2" : (op < 4) ? "R4" : (op < 6) ? "R5" : "R6";
    if ((cnt_raw >> 6) != 0) fam = {"R1/", fam};
    if (sz != 0 && (opnd >> 8) != 0) fam = {fam, "/R3"};
    @(negedge clk_i);
    op_i = 3'(op); size_i = 2'(sz); operand_i = opnd; count_i = CNT_W'(cnt_raw);
    extend_i = xin; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    k = 0;
    while (k < 100) begin
      @(posedge clk_i);
      @(negedge clk_i);
      k++;
      if (k == 2 && inject) begin
        start_i = 1'b1; operand_i = ~opnd; count_i = 8'h01; op_i = ~op_i; extend_i = ~xin;
      end
      if (k == 3 && inject) start_i = 1'b0;
      if (k == 2 && !done_o) begin
        chk(result_o == prev_res, "R10 hold", 64'(result_o), 64'(prev_res));
        chk(busy_o == 1'b1, "R9 busy", 64'(busy_o), 64'd1);
      end
      if (done_o) break;
    end
    chk(k == elat, inject ? "R8/R10 latency" : "R8 latency", 64'(k), 64'(elat));
    chk({result_o, carry_o, extend_o} == {er, ec, ex}, fam,
        {29'd0, result_o, carry_o, extend_o}, {29'd0, er, ec, ex});
    chk({neg_o, zero_o} == {en, ez}, "R3 nz", 64'({neg_o, zero_o}), 64'({en, ez}));
    chk(ovf_o == ev, "R7 ovf", 64'(ovf_o), 64'(ev));
    prev_res = result_o;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 pulse", 64'({done_o, busy_o}), 64'd0);
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({result_o, carry_o, extend_o, neg_o, zero_o, ovf_o, busy_o, done_o} == '0, "R11 reset",
        64'({result_o, carry_o, extend_o, neg_o, zero_o, ovf_o, busy_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    // full count sweep across every operation and size code
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int cnt = 0; cnt < 64; cnt++) begin
          int idx;
          logic [31:0] opnd;
          idx  = (op * 4 + sz) * 64 + cnt;
          opnd = (32'h9e37_79b9 * 32'(idx + 1)) ^ (32'(idx) << 13);
          run_op(op, sz, opnd, cnt | ((idx & 3) << 6), idx[1] ^ idx[4], 1'b0);
        end
      end
    end
    // corner operands on byte size
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 4; p++) begin
        for (int cnt = 0; cnt < 20; cnt++) begin
          logic [31:0] opnd;
          opnd = (p == 0) ? 32'h0 : (p == 1) ? 32'hff : (p == 2) ? 32'h80 : 32'h1;
          run_op(op, 0, opnd, cnt, p[0], 1'b0);
        end
      end
    end
    // start requests while busy
    for (int op = 0; op < 8; op++) begin
      run_op(op, op % 3, 32'hc3a5_5a3c, 12 + op, op[0], 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule